// File: doc/BRIEF.md
# Programmable Pulse Burst Generator with Interrupt Collector

The block produces a burst of one-clock sample pulses. Software programs the pulse spacing as a number of ticks, where a tick is a fixed number of system clocks chosen by a parameter. Writing the pulse-count register starts a burst of that many pulses. After the last pulse the block goes idle and stays idle until the count register is written again.

The end of each burst raises one bit of a seven-bit pending vector. Six external event strobes feed the other six bits. A bit becomes pending whenever its source fires, whether or not it is enabled. Software masks the vector with an enable register and clears bits by writing ones to a clear register. The interrupt output is high while any enabled bit is pending.

The host uses a simple register port. A write takes effect on the clock edge where the write strobe is sampled. Read data is combinational from the address. There is no streaming interface, so every pin is a plain control or status signal.

Top module: `pulse_burst_irq`

## Requirements
- R1: After reset the count register reads 256, the interval register reads 5156, the enable register reads 0 and the pending vector reads 0. `sample_pulse`, `burst_active` and `irq` are all low.
- R2: A write of a nonzero value N to the count register (byte address 0x0C) starts a burst of exactly N pulses, each one clock wide. No further pulse appears until the next count write. A write to the interval register (0x10) starts nothing.
- R3: With interval I ticks and a tick of CLK_PER_TICK clocks, pulse k appears in the k*I*CLK_PER_TICK-th cycle after the edge that takes the count write. An interval of 0 behaves as 1.
- R4: A count write of 0 stops a running burst with no further pulse. A nonzero count write during a burst restarts the timing and the pulse total from that write.
- R5: Reads return the count at 0x0C, the interval at 0x10, the enable register in bits 7:0 at 0x14, and the pending vector in bits 6:0 at 0x18. The clear address 0x1C and unmapped addresses read 0.
- R6: Pending bit 0 is set at the final pulse of a burst, and an aborted burst does not set it. Pending bits 6:1 are set by one-cycle strobes on `ext_evt[5:0]`, bit i+1 following `ext_evt[i]`. Both rules apply whether or not the bit is enabled.
- R7: A write to 0x1C clears every pending bit where the write data bit is 1. Bits where the write data is 0 are unchanged. Writes to 0x18 have no effect.
- R8: If a pending bit is set and cleared in the same cycle, it ends up set.
- R9: `irq` is high exactly while some bit in 6:0 is both pending and enabled. Enable bit 7 has no effect on `irq`.
- R10: `burst_active` goes high in the cycle after a nonzero count write. It goes low in the same cycle as the final pulse, or after a count write of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| ext_evt | input | 6 | One-cycle strobes of the other interrupt sources |
| sample_pulse | output | 1 | One-clock burst pulse |
| burst_active | output | 1 | A burst is in progress |
| irq | output | 1 | Any enabled pending bit |

## Verification
The assertions assume that reset is held for at least one clock. They also assume that the host port and `ext_evt` hold only defined values from time zero, because the pending-set checks compare against the previous cycle's strobes. The bench starts all inputs at zero and changes them only on falling edges. It raises each strobe for exactly one cycle, and it writes at most one register per cycle. The set-versus-clear collision is the only case in which a strobe and a write land in the same cycle.

// File: rtl/pbg_pkg.sv
package pbg_pkg;
  localparam int unsigned AW    = 8;
  localparam int unsigned DW    = 16;
  localparam int unsigned SRC_N = 7;
  localparam int unsigned IEN_W = 8;
  localparam int unsigned EXT_N = SRC_N - 1;

  localparam logic [AW-1:0] A_COUNT = 8'h0C;
  localparam logic [AW-1:0] A_IVL   = 8'h10;
  localparam logic [AW-1:0] A_IEN   = 8'h14;
  localparam logic [AW-1:0] A_PEND  = 8'h18;
  localparam logic [AW-1:0] A_CLR   = 8'h1C;

  // source index 0 is the burst-done event; 1..6 are external strobes
  localparam int unsigned SRC_BURST = 0;
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int unsigned DIV = 121
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  generate
    if (DIV > 1) begin : g_div
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (!rst_n || restart_i || !run_i) cnt_q <= '0;
        else if (cnt_q == LAST)            cnt_q <= '0;
        else                               cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = run_i && (cnt_q == LAST);

      // R3
      tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end else begin : g_pass
      assign tick_o = run_i;
    end
  endgenerate
endmodule

// File: rtl/burst_sequencer.sv
module burst_sequencer #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned IVL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [IVL_W-1:0] ivl_i,
  input  logic             tick_i,
  output logic             active_o,
  output logic             pulse_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);
  localparam logic [IVL_W-1:0] ONE_I = IVL_W'(1);

  logic             active_q, pulse_q, done_q;
  logic [CNT_W-1:0] left_q;
  logic [IVL_W-1:0] tkc_q;
  logic [IVL_W-1:0] ivl_eff;
  logic             slot_end;

  assign ivl_eff  = (ivl_i == '0) ? ONE_I : ivl_i;
  assign slot_end = ({1'b0, tkc_q} + {{IVL_W{1'b0}}, 1'b1}) >= {1'b0, ivl_eff};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pulse_q  <= 1'b0;
      done_q   <= 1'b0;
      left_q   <= '0;
      tkc_q    <= '0;
    end else if (start_i) begin
      active_q <= (count_i != '0);
      left_q   <= count_i;
      tkc_q    <= '0;
      pulse_q  <= 1'b0;
      done_q   <= 1'b0;
    end else if (active_q && tick_i) begin
      if (slot_end) begin
        tkc_q   <= '0;
        pulse_q <= 1'b1;
        left_q  <= left_q - ONE_C;
        if (left_q == ONE_C) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end else begin
          done_q   <= 1'b0;
        end
      end else begin
        tkc_q   <= tkc_q + ONE_I;
        pulse_q <= 1'b0;
        done_q  <= 1'b0;
      end
    end else begin
      pulse_q <= 1'b0;
      done_q  <= 1'b0;
    end
  end

  assign active_o = active_q;
  assign pulse_o  = pulse_q;
  assign done_o   = done_q;

  // R2
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> $past(tick_i));
  // R2
  left_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (left_q != '0));
  // R4
  end_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_q) |-> (pulse_q || $past(start_i)));
endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;

  // R8
  set_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((pend_q & $past(set_i)) == $past(set_i)));
  // R7
  clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_i)) |=> ((pend_q & $past(clr_i & ~set_i)) == '0));
  // R6
  no_phantom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q) & ~$past(set_i)) == '0));
endmodule

// File: rtl/pulse_burst_irq.sv
module pulse_burst_irq
  import pbg_pkg::*;
#(
  parameter int unsigned CLK_PER_TICK = 121,
  parameter int unsigned DEF_COUNT    = 256,
  parameter int unsigned DEF_IVL      = 5156
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [EXT_N-1:0] ext_evt,
  output logic          sample_pulse,
  output logic          burst_active,
  output logic          irq
);
  logic [DW-1:0]    count_q, ivl_q;
  logic [IEN_W-1:0] ien_q;
  logic [SRC_N-1:0] pend, set_v, clr_v;
  logic             start, tick, done;

  assign start = reg_wr && (reg_addr == A_COUNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= DW'(DEF_COUNT);
      ivl_q   <= DW'(DEF_IVL);
      ien_q   <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_COUNT: count_q <= reg_wdata;
        A_IVL:   ivl_q   <= reg_wdata;
        A_IEN:   ien_q   <= reg_wdata[IEN_W-1:0];
        default: ;
      endcase
    end
  end

  tick_prescaler #(.DIV(CLK_PER_TICK)) u_presc (
    .clk(clk), .rst_n(rst_n), .run_i(burst_active),
    .restart_i(start), .tick_o(tick)
  );

  burst_sequencer #(.CNT_W(DW), .IVL_W(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .count_i(reg_wdata),
    .ivl_i(ivl_q), .tick_i(tick), .active_o(burst_active),
    .pulse_o(sample_pulse), .done_o(done)
  );

  assign set_v = {ext_evt, done};
  assign clr_v = (reg_wr && reg_addr == A_CLR) ? reg_wdata[SRC_N-1:0] : '0;

  irq_pending #(.N(SRC_N)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_i(set_v), .clr_i(clr_v), .pend_o(pend)
  );

  assign irq = |(pend & ien_q[SRC_N-1:0]);

  always_comb begin
    case (reg_addr)
      A_COUNT: reg_rdata = count_q;
      A_IVL:   reg_rdata = ivl_q;
      A_IEN:   reg_rdata = {{(DW-IEN_W){1'b0}}, ien_q};
      A_PEND:  reg_rdata = {{(DW-SRC_N){1'b0}}, pend};
      default: reg_rdata = '0;
    endcase
  end

  // R10
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_active) |-> $past(start));
  // R6
  done_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> pend[SRC_BURST]);
endmodule

// File: tb/pulse_burst_irq_bench.sv
module pulse_burst_irq_bench;
  localparam int DIV = 4;
  localparam logic [7:0] A_CNT = 8'h0C, A_IVL = 8'h10, A_IEN = 8'h14,
                         A_PND = 8'h18, A_CLR = 8'h1C;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [5:0]  ext_evt = '0;
  logic sample_pulse, burst_active, irq;

  int n_tests = 0, n_fail = 0;
  int pcount;
  int pos [0:15];
  logic act_hist [0:255];

  always #4 clk = ~clk;

  pulse_burst_irq #(.CLK_PER_TICK(DIV)) u_pulse_burst_irq (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_evt(ext_evt),
    .sample_pulse(sample_pulse), .burst_active(burst_active), .irq(irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 8'h00; reg_wdata = '0;
    act_hist[0] = burst_active;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
    reg_addr = 8'h00;
  endtask

  task automatic watch(input int n);
    pcount = 0;
    for (int c = 1; c <= n; c++) begin
      @(negedge clk);
      act_hist[c] = burst_active;
      if (sample_pulse) begin
        if (pcount < 16) pos[pcount] = c;
        pcount++;
      end
    end
  endtask

  task automatic t_reset;
    logic [15:0] d;
    rd(A_CNT, d); chk("R1", "count default", d, 256);
    rd(A_IVL, d); chk("R1", "interval default", d, 5156);
    rd(A_IEN, d); chk("R1", "enable default", d, 0);
    rd(A_PND, d); chk("R1", "pending default", d, 0);
    chk("R1", "outputs idle", {sample_pulse, burst_active, irq}, 0);
    rd(A_CLR, d); chk("R5", "clear reads zero", d, 0);
    rd(8'h20, d); chk("R5", "unmapped reads zero", d, 0);
  endtask

  task automatic t_burst;
    logic [15:0] d;
    wr(A_IVL, 16'd2);
    chk("R2", "interval write starts nothing", burst_active, 0);
    rd(A_IVL, d); chk("R5", "interval readback", d, 2);
    wr(A_CNT, 16'd3);
    chk("R10", "active after count write", act_hist[0], 1);
    watch(40);
    chk("R2", "pulse total", pcount, 3);
    chk("R3", "pulse 1 cycle", pos[0], 8);
    chk("R3", "pulse 2 cycle", pos[1], 16);
    chk("R3", "pulse 3 cycle", pos[2], 24);
    chk("R10", "active before last pulse", act_hist[23], 1);
    chk("R10", "inactive at last pulse", act_hist[24], 0);
    rd(A_CNT, d); chk("R5", "count readback", d, 3);
    rd(A_PND, d); chk("R6", "done bit pending", d, 16'h0001);
    wr(A_CLR, 16'h007F);
  endtask

  task automatic t_ivl_zero;
    wr(A_IVL, 16'd0);
    wr(A_CNT, 16'd2);
    watch(20);
    chk("R3", "zero interval total", pcount, 2);
    chk("R3", "zero interval pulse 1", pos[0], 4);
    chk("R3", "zero interval pulse 2", pos[1], 8);
  endtask

  task automatic t_stop_restart;
    logic [15:0] d;
    wr(A_CLR, 16'h007F);
    wr(A_IVL, 16'd1);
    wr(A_CNT, 16'd10);
    watch(6);
    chk("R4", "pulse before stop", pcount, 1);
    wr(A_CNT, 16'd0);
    chk("R10", "inactive after zero write", act_hist[0], 0);
    watch(30);
    chk("R4", "no pulse after stop", pcount, 0);
    rd(A_PND, d); chk("R6", "aborted burst leaves done clear", d, 0);
    wr(A_CNT, 16'd5);
    watch(6);
    wr(A_CNT, 16'd2);
    watch(20);
    chk("R4", "restart total", pcount, 2);
    chk("R4", "restart timing", pos[0], 4);
    rd(A_PND, d); chk("R6", "restart ends with done", d, 16'h0001);
  endtask

  task automatic t_irq;
    logic [15:0] d;
    wr(A_CLR, 16'h007F);
    @(negedge clk); ext_evt = 6'b000100;
    @(negedge clk); ext_evt = '0;
    rd(A_PND, d); chk("R6", "external strobe sets bit 3", d, 16'h0008);
    chk("R9", "irq low when disabled", irq, 0);
    wr(A_IEN, 16'h0080);
    chk("R9", "enable bit 7 has no effect", irq, 0);
    rd(A_IEN, d); chk("R5", "enable readback", d, 16'h0080);
    wr(A_IEN, 16'h0008);
    chk("R9", "irq high when enabled", irq, 1);
    wr(A_CLR, 16'h0000);
    rd(A_PND, d); chk("R7", "zero clear keeps bit", d, 16'h0008);
    wr(A_PND, 16'h0000);
    rd(A_PND, d); chk("R7", "vector write ignored", d, 16'h0008);
    wr(A_CLR, 16'h0008);
    rd(A_PND, d); chk("R7", "one clears bit", d, 0);
    chk("R9", "irq drops after clear", irq, 0);
  endtask

  task automatic t_set_wins;
    logic [15:0] d;
    @(negedge clk);
    ext_evt = 6'b000001; reg_wr = 1'b1; reg_addr = A_CLR; reg_wdata = 16'h0002;
    @(negedge clk);
    ext_evt = '0; reg_wr = 1'b0; reg_addr = 8'h00; reg_wdata = '0;
    rd(A_PND, d); chk("R8", "set beats clear", d, 16'h0002);
    wr(A_IEN, 16'h0002);
    chk("R9", "irq from bit 1", irq, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_burst;
    t_ivl_zero;
    t_stop_restart;
    t_irq;
    t_set_wins;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule